// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches up to 32 asynchronous external lines and turns selected transitions on them into interrupt and wake-up signalling. Every line is first brought into the clock domain by a two-stage synchroniser. Its edge detector can then be armed for rising transitions, falling transitions or both. A detected, armed edge latches a per-line pending flag and, independently, can emit a one-cycle event pulse on that line's event output. The single interrupt request output is high while any pending line is also enabled for interrupts.

Software reaches the block through a plain 32-bit register port: a byte offset, a write strobe, write data and combinational read data. Six registers hold the per-line interrupt enables, event enables, rising and falling selects, a software trigger and the pending flags. Writing ones to the pending register clears flags. Bit positions at or above the configured line count always read as zero, so software can find the line count by writing all ones to a select register and reading it back. There is no data stream, so there is no valid/ready handshake and no back-pressure. A write takes effect on the clock edge where the strobe is sampled.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0 and `evt_o` is all zeros.
- R2: The interrupt enable (0x00), event enable (0x04), rising select (0x08) and falling select (0x0C) registers read back what was written in bit positions below NUM_LINES; bit positions at or above NUM_LINES read 0. With NUM_LINES = 16, writing 0xFFFFFFFF to 0x08 reads back as 0x0000FFFF.
- R3: A line whose only armed edge is rising sets its pending bit (register 0x14, bit = line index) on a 0-to-1 input change and not on a 1-to-0 change.
- R4: A line whose only armed edge is falling sets its pending bit on a 1-to-0 change and not on a 0-to-1 change. A line with neither edge armed never becomes pending.
- R5: A line with both select bits set becomes pending on either transition.
- R6: When the input changes just before clock edge N, the pending bit and the event pulse appear after clock edge N+2. This is two synchroniser stages plus one capture stage.
- R7: Writing a 1 to a bit of the pending register clears that bit. Writing a 0 leaves the bit unchanged.
- R8: If an armed edge and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R9: `irq_o` is 1 exactly when some line has both its pending bit and its interrupt enable bit set. A pending but disabled line does not raise it, and enabling that line later does raise it.
- R10: When an armed edge occurs on a line whose event enable bit is 1, `evt_o` for that line is 1 for exactly one cycle. This does not depend on the interrupt enable or the pending state. A line with event enable 0 produces no pulse.
- R11: Writing a 1 to a bit of the software trigger register (0x10) sets that line's pending bit. That software trigger bit then reads 1 until the pending bit is cleared, after which it reads 0.
- R12: Reads of any offset other than the six registers return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ext_in | input | NUM_LINES | Asynchronous external lines |
| irq_o | output | 1 | Combined interrupt request |
| evt_o | output | NUM_LINES | Per-line wake-up event pulses |

## Verification
A corrupted pending flag shows up at once in two places: in a read of offset 0x14 and, when the line is enabled, as `irq_o` stuck high or low. A wrong synchroniser or edge stage shows up three cycles after an input change, as a pending bit or event pulse that is missing, early, late, or raised on the wrong polarity. A stale software trigger bit is seen on the first read of 0x10 after its pending flag is cleared. A set/clear priority fault is seen on the read that follows a clear timed onto the capture edge.

// File: rtl/eic_pkg.sv
`timescale 1ns/1ps
package eic_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    OFS_IRQ_EN = 5'h00,
    OFS_EVT_EN = 5'h04,
    OFS_RISE   = 5'h08,
    OFS_FALL   = 5'h0C,
    OFS_SOFT   = 5'h10,
    OFS_PEND   = 5'h14
  } reg_ofs_e;
endpackage

// File: rtl/eic_edge_detect.sv
`timescale 1ns/1ps
module eic_edge_detect #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pins_i,
  input  logic [NUM_LINES-1:0] rise_sel_i,
  input  logic [NUM_LINES-1:0] fall_sel_i,
  output logic [NUM_LINES-1:0] hit_o
);
  logic [NUM_LINES-1:0] rise_w, fall_w;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pins_i[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign rise_w[g] = sync_q & ~prev_q;
    assign fall_w[g] = ~sync_q & prev_q;
  end

  assign hit_o = (rise_w & rise_sel_i) | (fall_w & fall_sel_i);

  // R4: an unarmed line never produces a hit
  a_r4_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o & ~(rise_sel_i | fall_sel_i)) == '0);
endmodule

// File: rtl/eic_pending.sv
`timescale 1ns/1ps
module eic_pending #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] set_i,
  input  logic [NUM_LINES-1:0] clr_i,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  a_r7_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i & ~set_i) != '0 |=> (pend_o & $past(clr_i & ~set_i)) == '0);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i != '0 |=> (pend_o & $past(set_i)) == $past(set_i));

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(pend_o));
endmodule

// File: rtl/ext_irq_ctrl.sv
`timescale 1ns/1ps
module ext_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  input  logic [NUM_LINES-1:0] ext_in,
  output logic                 irq_o,
  output logic [NUM_LINES-1:0] evt_o
);
  localparam logic [REG_W:0]   MASK_WIDE = (33'd1 << NUM_LINES) - 33'd1;
  localparam logic [REG_W-1:0] LINE_MASK = MASK_WIDE[REG_W-1:0];

  logic [NUM_LINES-1:0] irq_en_q, evt_en_q, rise_q, fall_q, soft_q, evt_q;
  logic [NUM_LINES-1:0] hit, pend, wdat, soft_set, pend_clr;
  logic [NUM_LINES-1:0] rd_n;
  logic unused_wdata;

  assign wdat         = bus_wdata[NUM_LINES-1:0];
  assign unused_wdata = ^(bus_wdata & ~LINE_MASK);
  assign soft_set     = (bus_we && bus_addr == OFS_SOFT) ? wdat : '0;
  assign pend_clr     = (bus_we && bus_addr == OFS_PEND) ? wdat : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= '0;
      evt_en_q <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_IRQ_EN: irq_en_q <= wdat;
        OFS_EVT_EN: evt_en_q <= wdat;
        OFS_RISE:   rise_q   <= wdat;
        OFS_FALL:   fall_q   <= wdat;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_q <= '0;
      evt_q  <= '0;
    end else begin
      soft_q <= soft_set | (soft_q & ~pend_clr);
      evt_q  <= hit & evt_en_q;
    end
  end

  eic_edge_detect #(.NUM_LINES(NUM_LINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pins_i(ext_in),
    .rise_sel_i(rise_q), .fall_sel_i(fall_q), .hit_o(hit)
  );

  eic_pending #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(hit | soft_set),
    .clr_i(pend_clr), .pend_o(pend)
  );

  assign irq_o = |(pend & irq_en_q);
  assign evt_o = evt_q;

  always_comb begin
    rd_n = '0;
    case (bus_addr)
      OFS_IRQ_EN: rd_n = irq_en_q;
      OFS_EVT_EN: rd_n = evt_en_q;
      OFS_RISE:   rd_n = rise_q;
      OFS_FALL:   rd_n = fall_q;
      OFS_SOFT:   rd_n = soft_q;
      OFS_PEND:   rd_n = pend;
      default:    rd_n = '0;
    endcase
    bus_rdata = '0;
    bus_rdata[NUM_LINES-1:0] = rd_n;
  end

  // R10: event pulses only on lines whose event enable was set
  a_r10_evt_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (evt_o & ~$past(evt_en_q)) == '0);

  // R11: a software trigger write leaves the line pending next cycle
  a_r11_soft_pends: assert property (@(posedge clk) disable iff (!rst_n)
    soft_set != '0 |=> (pend & $past(soft_set)) == $past(soft_set));
endmodule

// File: tb/ext_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ext_irq_ctrl_bench;
  localparam int N = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] ext_in = '0, evt_o;
  logic irq_o;
  int n_checks = 0, n_fail = 0;

  always #2 clk = ~clk;

  ext_irq_ctrl #(.NUM_LINES(N)) u_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in),
    .irq_o(irq_o), .evt_o(evt_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  // change one line, then stop at the negedge after the third posedge
  task automatic drive_line(int idx, logic v);
    @(negedge clk);
    ext_in[idx] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), d);
      check("R1/R12 reset read", d, 32'h0);
    end
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 evt", {16'b0, evt_o}, 32'h0);
    rd(5'h18, d); check("R12 unmapped 0x18", d, 32'h0);
    rd(5'h1C, d); check("R12 unmapped 0x1C", d, 32'h0);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, d); check("R2 rise width", d, 32'h0000_FFFF);
    wr(5'h00, 32'h1234_A5A5); rd(5'h00, d); check("R2 irq_en", d, 32'h0000_A5A5);
    wr(5'h04, 32'hFFFF_5A5A); rd(5'h04, d); check("R2 evt_en", d, 32'h0000_5A5A);
    wr(5'h0C, 32'h8000_00C3); rd(5'h0C, d); check("R2 fall", d, 32'h0000_00C3);
    wr(5'h00, 0); wr(5'h04, 0); wr(5'h08, 0); wr(5'h0C, 0);
  endtask

  task automatic t_rising;
    logic [31:0] d;
    wr(5'h08, 32'h1); wr(5'h00, 32'h1);
    @(negedge clk); ext_in[0] = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    rd(5'h14, d); check("R6 not yet pending", d, 32'h0);
    @(posedge clk); @(negedge clk);
    rd(5'h14, d); check("R3/R6 rise pending", d, 32'h1);
    check("R9 irq on", {31'b0, irq_o}, 32'h1);
    wr(5'h14, 32'h1);
    rd(5'h14, d); check("R7 cleared", d, 32'h0);
    check("R9 irq off", {31'b0, irq_o}, 32'h0);
    drive_line(0, 1'b0); @(negedge clk);
    rd(5'h14, d); check("R3 fall ignored", d, 32'h0);
    wr(5'h00, 0);
  endtask

  task automatic t_falling;
    logic [31:0] d;
    wr(5'h0C, 32'h2);
    drive_line(1, 1'b1); @(negedge clk);
    rd(5'h14, d); check("R4 rise ignored", d, 32'h0);
    drive_line(1, 1'b0);
    rd(5'h14, d); check("R4 fall pending", d, 32'h2);
    drive_line(3, 1'b1); drive_line(3, 1'b0); @(negedge clk);
    rd(5'h14, d); check("R4 unarmed line", d, 32'h2);
  endtask

  task automatic t_both_and_clear;
    logic [31:0] d;
    wr(5'h08, 32'h5); wr(5'h0C, 32'h6);
    drive_line(2, 1'b1);
    rd(5'h14, d); check("R5 rise pending", d, 32'h6);
    wr(5'h14, 32'h4);
    rd(5'h14, d); check("R7 one bit cleared", d, 32'h2);
    wr(5'h14, 32'h0);
    rd(5'h14, d); check("R7 zero write no effect", d, 32'h2);
    drive_line(2, 1'b0);
    rd(5'h14, d); check("R5 fall pending", d, 32'h6);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    @(negedge clk); ext_in[2] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    bus_addr = 5'h14; bus_wdata = 32'h4; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
    rd(5'h14, d); check("R8 set beats clear", d, 32'h6);
  endtask

  task automatic t_irq_mask;
    wr(5'h00, 32'h1);
    check("R9 disabled pending quiet", {31'b0, irq_o}, 32'h0);
    wr(5'h00, 32'h2);
    check("R9 enable raises irq", {31'b0, irq_o}, 32'h1);
    wr(5'h14, 32'hFFFF); wr(5'h00, 0);
    check("R9 all cleared", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_event;
    wr(5'h04, 32'h1); wr(5'h08, 32'h1);
    drive_line(0, 1'b1);
    check("R10 pulse", {16'b0, evt_o}, 32'h1);
    @(negedge clk);
    check("R10 single cycle", {16'b0, evt_o}, 32'h0);
    wr(5'h14, 32'h1);
    drive_line(2, 1'b0);
    check("R10 no evt on disabled line", {16'b0, evt_o}, 32'h0);
    wr(5'h04, 32'h0); wr(5'h0C, 32'h1);
    drive_line(0, 1'b0);
    check("R10 masked no pulse", {16'b0, evt_o}, 32'h0);
    wr(5'h14, 32'hFFFF);
  endtask

  task automatic t_soft;
    logic [31:0] d;
    wr(5'h10, 32'h8);
    rd(5'h14, d); check("R11 soft pending", d, 32'h8);
    rd(5'h10, d); check("R11 soft reads one", d, 32'h8);
    wr(5'h14, 32'h8);
    rd(5'h10, d); check("R11 soft cleared", d, 32'h0);
    rd(5'h14, d); check("R11 pending cleared", d, 32'h0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_readback();
    t_rising();
    t_falling();
    t_both_and_clear();
    t_set_wins();
    t_irq_mask();
    t_event();
    t_soft();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule